// File: doc/BRIEF.md
# Dual-Mode Delay Setting Port

This block owns the 8-bit code that selects the tap of a programmable delay element. A static mode input decides how the code is loaded. With the mode input low the code comes from an 8-bit parallel bus through a transparent latch. While the latch enable is high the code follows the bus, and while it is low the code is frozen. Tying the enable high makes the code track the bus from the first cycles after reset.

With the mode input high the block is a 3-wire shift-register port. While the enable is high, each rising edge of the serial clock moves one data bit into an internal register, most significant bit first. The register's top bit is driven on a serial output, so several ports can be chained and the stored code can be read back. The read is nondestructive only if that output is looped back to the data input. The shifted value becomes the active code on the falling edge of the enable. The serial output is switched off (its enable is low) whenever the enable is low or the block is in parallel mode.

The serial clock and the enable come from pins and are synchronized into the system clock with two flops each. The data pins are sampled in the system clock domain. The active code resets to 0x00. A one-cycle flag marks every clock in which the active code takes a new value.

Top module: `dly_setting_port`

## Requirements
- R1: During and after reset the active code is 0x00, the change flag is 0 and the serial output enable is 0.
- R2: In parallel mode (modeSerial = 0) with the latch enable high, the active code takes the value of the 8-bit parallel bus within a few system clocks.
- R3: In parallel mode with the latch enable low, the active code holds its value whatever the bus does.
- R4: In serial mode (modeSerial = 1) with the latch enable high, each rising serial clock edge shifts serDin into bit 0 of the shift register, with earlier bits moving toward bit 7 (MSB first). The active code does not change while shifting.
- R5: In serial mode the shift register content becomes the active code when the synchronized latch enable falls.
- R6: The serial output presents bit 7 of the shift register. Before the first shift this is bit 7 of the active code, and each shift exposes the next lower old bit. Its enable is 1 only in serial mode with the latch enable high.
- R7: Shifting 8 bits with serDin fed from the serial output leaves the active code unchanged after commit. Shifting 8 bits of other data replaces it.
- R8: Three chained ports, each taking the previous port's serial output as its data input, receive three codes in one 24-clock access. The first code shifted lands in the last port.
- R9: The change flag is high for exactly one system clock each time the active code takes a different value, and stays low when a load or commit writes the same value.
- R10: The parallel bus has no effect in serial mode, and the serial clock has no effect in parallel mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| modeSerial | input | 1 | 0 = parallel loading, 1 = serial loading |
| latchEn | input | 1 | Latch enable / serial frame enable (asynchronous pin) |
| parBus | input | 8 | Parallel code input |
| serClk | input | 1 | Serial shift clock (asynchronous pin) |
| serDin | input | 1 | Serial data input |
| serDout | output | 1 | Serial data output (shift register bit 7) |
| serDoutEn | output | 1 | Output enable for serDout; 0 means high impedance |
| setting | output | 8 | Active delay code |
| settingChanged | output | 1 | One-cycle pulse on each change of the active code |

## Verification
The bench first checks that the parallel bus is held while the enable is low, and that a bus value equal to the current code raises no flag. A design that skipped either would alter the code or flag a change that did not happen. In serial mode it reads the old code bit by bit from the serial output while new bits go in. It checks that the active code stays put until the enable falls, which catches a port that commits on every shift or shifts LSB first. It runs a looped-back read and a destructive read, and a 24-bit access through three chained ports, where an off-by-one in the shift path would place a code in the wrong port. Finally it drives the unused interface in each mode to confirm it is ignored.

// File: rtl/dly_setting_pkg.sv
package dly_setting_pkg;

  // strobes issued by the control module to the datapath
  typedef struct packed {
    logic shift;    // move serDin into the shift register
    logic loadPar;  // copy the parallel bus into the active code
    logic commit;   // copy the shift register into the active code
  } ctrlStb_t;

endpackage

// File: rtl/dly_setting_ctrl.sv
module dly_setting_ctrl
  import dly_setting_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     modeSerial,
  input  logic     latchEn,
  input  logic     serClk,
  output ctrlStb_t stb,
  output logic     qEnable
);

  localparam int NUM_SYNC = 2;
  localparam int IDX_LE   = 0;
  localparam int IDX_SC   = 1;

  logic [NUM_SYNC-1:0] rawPins;
  logic [NUM_SYNC-1:0] syncOut;
  logic [NUM_SYNC-1:0] syncLast;

  assign rawPins = {serClk, latchEn};

  genvar g;
  generate
    for (g = 0; g < NUM_SYNC; g++) begin : gSync
      logic [SYNC_STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain <= '0;
        else       chain <= {chain[SYNC_STAGES-2:0], rawPins[g]};
      end
      assign syncOut[g] = chain[SYNC_STAGES-1];
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncLast <= '0;
    else       syncLast <= syncOut;
  end

  logic leHigh;
  logic leFall;
  logic scRise;

  assign leHigh = syncOut[IDX_LE];
  assign leFall = syncLast[IDX_LE] && !syncOut[IDX_LE];
  assign scRise = syncOut[IDX_SC] && !syncLast[IDX_SC];

  always_comb begin
    stb         = '0;
    stb.shift   = modeSerial && leHigh && scRise;
    stb.commit  = modeSerial && leFall;
    stb.loadPar = !modeSerial && leHigh;
  end

  assign qEnable = modeSerial && leHigh;

  AST_STROBE_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.shift, stb.loadPar, stb.commit})); // R10

  AST_NO_SHIFT_PARALLEL: assert property (@(posedge clk) disable iff (!rstN)
    !modeSerial |-> !stb.shift && !stb.commit); // R10

endmodule

// File: rtl/dly_setting_dp.sv
module dly_setting_dp
  import dly_setting_pkg::*;
#(
  parameter int CODE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStb_t          stb,
  input  logic [CODE_W-1:0] parBus,
  input  logic              serDin,
  output logic [CODE_W-1:0] activeCode,
  output logic              codeChanged,
  output logic              qBit
);

  localparam int MSB = CODE_W - 1;

  logic [CODE_W-1:0] shiftReg;
  logic [CODE_W-1:0] nextCode;
  logic              doUpdate;

  always_comb begin
    nextCode = activeCode;
    doUpdate = 1'b0;
    if (stb.loadPar) begin
      nextCode = parBus;
      doUpdate = 1'b1;
    end else if (stb.commit) begin
      nextCode = shiftReg;
      doUpdate = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      activeCode  <= '0;
      codeChanged <= 1'b0;
    end else begin
      activeCode  <= nextCode;
      codeChanged <= doUpdate && (nextCode != activeCode);
    end
  end

  // shift register mirrors the active code whenever it is not being shifted,
  // so the first bit shifted out is the old MSB
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            shiftReg <= '0;
    else if (stb.shift)   shiftReg <= {shiftReg[MSB-1:0], serDin};
    else if (stb.loadPar) shiftReg <= parBus;
  end

  assign qBit = shiftReg[MSB];

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.loadPar || stb.commit) |=> $stable(activeCode)); // R3

  AST_SHIFT_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    stb.shift |=> $stable(activeCode)); // R4

  AST_FLAG_ON_CHANGE: assert property (@(posedge clk) disable iff (!rstN)
    (activeCode != $past(activeCode)) |-> codeChanged); // R9

  AST_FLAG_ONLY_CHANGE: assert property (@(posedge clk) disable iff (!rstN)
    codeChanged |-> (activeCode != $past(activeCode))); // R9

endmodule

// File: rtl/dly_setting_port.sv
module dly_setting_port
  import dly_setting_pkg::*;
#(
  parameter int CODE_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              modeSerial,
  input  logic              latchEn,
  input  logic [CODE_W-1:0] parBus,
  input  logic              serClk,
  input  logic              serDin,
  output logic              serDout,
  output logic              serDoutEn,
  output logic [CODE_W-1:0] setting,
  output logic              settingChanged
);

  ctrlStb_t stb;
  logic     qBit;
  logic     qEnable;

  dly_setting_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .modeSerial (modeSerial),
    .latchEn    (latchEn),
    .serClk     (serClk),
    .stb        (stb),
    .qEnable    (qEnable)
  );

  dly_setting_dp #(.CODE_W(CODE_W)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .stb         (stb),
    .parBus      (parBus),
    .serDin      (serDin),
    .activeCode  (setting),
    .codeChanged (settingChanged),
    .qBit        (qBit)
  );

  assign serDout   = qEnable ? qBit : 1'b0;
  assign serDoutEn = qEnable;

  AST_OE_SERIAL_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    serDoutEn |-> modeSerial); // R6

endmodule

// File: tb/dly_setting_port_tb.sv
module dly_setting_port_tb;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       modeSerial = 1'b0;
  logic       latchEn = 1'b0;
  logic [7:0] parBus = 8'h00;
  logic       serClk = 1'b0;
  logic       serDin = 1'b0;
  logic       dout0, dout1, dout2, oe0, oe1, oe2, chg1, chg2;
  logic [7:0] setting, set1, set2;
  logic       settingChanged;

  int tests = 0;
  int fails = 0;
  int pulseCnt = 0;
  bit done = 0;

  always #5 clk = ~clk;

  dly_setting_port u_dut (
    .clk(clk), .rstN(rstN), .modeSerial(modeSerial), .latchEn(latchEn),
    .parBus(parBus), .serClk(serClk), .serDin(serDin), .serDout(dout0),
    .serDoutEn(oe0), .setting(setting), .settingChanged(settingChanged));

  dly_setting_port u_dut2 (
    .clk(clk), .rstN(rstN), .modeSerial(modeSerial), .latchEn(latchEn),
    .parBus(parBus), .serClk(serClk), .serDin(dout0), .serDout(dout1),
    .serDoutEn(oe1), .setting(set1), .settingChanged(chg1));

  dly_setting_port u_dut3 (
    .clk(clk), .rstN(rstN), .modeSerial(modeSerial), .latchEn(latchEn),
    .parBus(parBus), .serClk(serClk), .serDin(dout1), .serDout(dout2),
    .serDoutEn(oe2), .setting(set2), .settingChanged(chg2));

  always @(negedge clk) if (settingChanged) pulseCnt++;

  task automatic check(input string req, input int actual, input int expected);
    tests++;
    if (actual != expected) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, actual, expected);
    end
  endtask

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setLe(input logic v);
    @(negedge clk) latchEn = v;
    waitN(5);
  endtask

  // one serial bit; returns the serial output seen before the clock rise
  task automatic shiftBit(input logic d, input bit loop, output logic q);
    @(negedge clk);
    q = dout0;
    serDin = loop ? q : d;
    serClk = 1'b1;
    waitN(4);
    serClk = 1'b0;
    waitN(4);
  endtask

  // parallel vectors: {latchEn, bus, expected code, expected pulses}
  localparam logic [18:0] VEC [8] = '{
    {1'b1, 8'hA5, 8'hA5, 2'd1},
    {1'b1, 8'hA5, 8'hA5, 2'd0},
    {1'b0, 8'h3C, 8'hA5, 2'd0},
    {1'b0, 8'hFF, 8'hA5, 2'd0},
    {1'b1, 8'hFF, 8'hFF, 2'd1},
    {1'b1, 8'h00, 8'h00, 2'd1},
    {1'b0, 8'h81, 8'h00, 2'd0},
    {1'b1, 8'h81, 8'h81, 2'd1}
  };

  initial begin
    int p0;
    logic q;
    logic [7:0] got;
    logic [7:0] vals [3];

    // R1 reset state
    waitN(3);
    check("R1 setting in reset", setting, 8'h00);
    check("R1 flag in reset", settingChanged, 0);
    rstN = 1'b1;
    waitN(3);
    check("R1 setting after reset", setting, 8'h00);
    check("R1 dout enable", oe0, 0);

    // R2 R3 R9 parallel vector table
    for (int i = 0; i < 8; i++) begin
      p0 = pulseCnt;
      @(negedge clk) latchEn = VEC[i][18];
      waitN(4);
      parBus = VEC[i][17:10];
      waitN(6);
      check(VEC[i][18] ? "R2 parallel follow" : "R3 parallel hold",
            setting, VEC[i][9:2]);
      check("R9 pulse count", pulseCnt - p0, VEC[i][1:0]);
      check("R6 dout off in parallel", oe0, 0);
    end

    // R10 serial clock ignored in parallel mode
    setLe(1'b0);
    for (int i = 0; i < 4; i++) shiftBit(1'b0, 0, q);
    check("R10 serClk ignored in parallel", setting, 8'h81);

    // R4 R5 R6 serial write reading old value
    modeSerial = 1'b1;
    waitN(3);
    check("R6 dout off while LE low", oe0, 0);
    setLe(1'b1);
    check("R6 dout on while LE high", oe0, 1);
    p0 = pulseCnt;
    got = '0;
    for (int b = 7; b >= 0; b--) begin
      shiftBit(8'h4E >> b, 0, q);
      got = {got[6:0], q};
    end
    check("R6 old value on dout MSB first", got, 8'h81);
    check("R4 code held while shifting", setting, 8'h81);
    setLe(1'b0);
    check("R5 commit on LE fall", setting, 8'h4E);
    check("R9 one pulse on commit", pulseCnt - p0, 1);
    check("R6 dout off after LE fall", oe0, 0);

    // R7 looped-back read
    setLe(1'b1);
    p0 = pulseCnt;
    got = '0;
    for (int b = 0; b < 8; b++) begin
      shiftBit(1'b0, 1, q);
      got = {got[6:0], q};
    end
    check("R7 readback value", got, 8'h4E);
    setLe(1'b0);
    check("R7 loop read keeps code", setting, 8'h4E);
    check("R9 no pulse on same value", pulseCnt - p0, 0);

    // R10 parallel bus ignored in serial mode
    setLe(1'b1);
    parBus = 8'hC3;
    waitN(6);
    parBus = 8'h18;
    waitN(6);
    check("R10 bus ignored in serial", setting, 8'h4E);

    // R7 destructive read (ones shifted in)
    for (int b = 0; b < 8; b++) shiftBit(1'b1, 0, q);
    setLe(1'b0);
    check("R7 destructive read", setting, 8'hFF);

    // R8 chain of three, 24 clocks
    vals[0] = 8'h5A; vals[1] = 8'h96; vals[2] = 8'h0F;
    setLe(1'b1);
    for (int d = 2; d >= 0; d--)
      for (int b = 7; b >= 0; b--) shiftBit(vals[d] >> b, 0, q);
    setLe(1'b0);
    check("R8 chain first port", setting, 8'h5A);
    check("R8 chain second port", set1, 8'h96);
    check("R8 chain third port", set2, 8'h0F);

    // R1 reset mid-run
    @(negedge clk) rstN = 1'b0;
    waitN(2);
    check("R1 reset clears code", setting, 8'h00);
    check("R1 reset clears dout enable", oe0, 0);
    rstN = 1'b1;

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule